// File: doc/BRIEF.md
# Inactivity-Driven Wake/Sleep Rate Controller

This block moves a sensing device between two operating states, Wake and Sleep, and picks the output data rate code for each. While awake with sleep switching enabled, it times a stretch of inactivity by counting sample strobes of the active rate. When the programmed duration passes with no qualifying activity, it drops into Sleep. Qualifying activity in Sleep brings it back to Wake.

The inactivity time is the 8-bit duration value multiplied by a step length. A step lasts 320 ms at every rate from 800 Hz down to 6.25 Hz, and 640 ms at 1.56 Hz. Each event source follows its own rule. The four detector sources restart the timer and wake the part. The FIFO source only restarts the timer. The data-ready source is ignored. Every state change sets a sticky interrupt flag. In gate mode, a state change still happens as usual, but FIFO intake freezes until the host flushes the FIFO or clears the flag.

The state machine has two states, `ST_WAKE` and `ST_SLEEP`, and three transitions:
- T_EXPIRE (`ST_WAKE` to `ST_SLEEP`): the timer expires.
- T_WAKE_EVT (`ST_SLEEP` to `ST_WAKE`): a detector event arrives.
- T_DISABLE (`ST_SLEEP` to `ST_WAKE`): the enable bit is cleared.

Top module: `inact_sleep_ctrl`

## Requirements
- R1: After reset the block is in Wake, `rate_sel` equals `wake_rate`, `irq_flag` is 0 and `fifo_accept` is 1.
- R2: Rate codes are 0=800 Hz, 1=400, 2=200, 3=100, 4=50, 5=12.5, 6=6.25, 7=1.56 Hz. `rate_sel` shows `wake_rate` in Wake and `sleep_rate` in Sleep.
- R3: In Wake with `slp_en`=1 and no restart event, the block enters Sleep on the (D*S+1)-th strobe after the last reload. D is `dur`. S is the number of samples per step for `wake_rate`: 256, 128, 64, 32, 16, 4, 2 or 1 for codes 0 to 7. The new state is visible after that clock edge.
- R4: While `slp_en` is 0 the block stays in Wake, and the timer is held at zero. Clearing `slp_en` in Sleep returns the block to Wake (T_DISABLE).
- R5: Event bits 0 to 3 of `evt_src` (transient, orientation, pulse, motion) restart the timer and wake the block from Sleep.
- R6: Event bit 4 (FIFO) restarts the timer but does not wake the block from Sleep.
- R7: Event bit 5 (data ready) neither restarts the timer nor wakes the block.
- R8: If a restart event arrives in the same cycle as the strobe that would expire the timer, the restart wins and the block stays in Wake.
- R9: Every transition sets `irq_flag`. `irq_clr` clears it. A transition in the same cycle as `irq_clr` leaves the flag set.
- R10: If `fifo_gate` is 1 when a transition occurs, `fifo_accept` drops to 0 and the state change still happens. `fifo_flush`, `irq_clr` or `fifo_gate`=0 restores it, and a new gated transition wins over the release. With `fifo_gate` at 0, `fifo_accept` stays 1.
- R11: With `dur`=0, the block sleeps on the first strobe that has no restart event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe per sample of the active rate |
| wake_rate | input | 3 | Rate code used in Wake |
| sleep_rate | input | 3 | Rate code used in Sleep |
| slp_en | input | 1 | Enables automatic sleep switching |
| dur | input | DUR_W | Inactivity duration in steps |
| fifo_gate | input | 1 | Makes a transition freeze FIFO intake |
| fifo_flush | input | 1 | Host flush pulse, releases the freeze |
| irq_clr | input | 1 | Clears the interrupt flag and the freeze |
| evt_src | input | SRC_N | Event pulses, bit order as in R5 to R7 |
| in_sleep | output | 1 | 1 while in Sleep |
| rate_sel | output | 3 | Selected rate code |
| irq_flag | output | 1 | Sticky transition flag |
| fifo_accept | output | 1 | FIFO may accept new samples |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a timer restart and a timer expiry. The bench raises a restart event together with the strobe that would otherwise end the count, and expects the block to stay in Wake. This is R8.

The second pair is a flag set and a flag clear. Random pulses on `irq_clr` and `fifo_flush` often land on a transition edge. The bench reference model requires that the set win in both the flag and the FIFO freeze.

// File: rtl/inact_pkg.sv
package inact_pkg;

    localparam int RATE_W = 3;
    localparam int STEP_W = 8;

    typedef enum logic {
        ST_WAKE  = 1'b0,
        ST_SLEEP = 1'b1
    } inact_st_e;

    // last index of the step counter: samples per step minus one
    function automatic logic [STEP_W-1:0] step_last(input logic [RATE_W-1:0] code);
        logic [STEP_W-1:0] r;
        unique case (code)
            3'd0:    r = 8'd255;
            3'd1:    r = 8'd127;
            3'd2:    r = 8'd63;
            3'd3:    r = 8'd31;
            3'd4:    r = 8'd15;
            3'd5:    r = 8'd3;
            3'd6:    r = 8'd1;
            default: r = 8'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/inact_evt_class.sv
module inact_evt_class #(
    parameter int             SRC_N     = 6,
    parameter logic [SRC_N-1:0] RST_MASK  = 6'b011111,
    parameter logic [SRC_N-1:0] WAKE_MASK = 6'b001111
) (
    input  logic [SRC_N-1:0] src,
    output logic             restart,
    output logic             wake
);

    logic [SRC_N-1:0] rst_hit;
    logic [SRC_N-1:0] wake_hit;

    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        assign rst_hit[i]  = RST_MASK[i]  & src[i];
        assign wake_hit[i] = WAKE_MASK[i] & src[i];
    end

    assign restart = |rst_hit;
    assign wake    = |wake_hit;

endmodule

// File: rtl/inact_step_timer.sv
module inact_step_timer
    import inact_pkg::*;
#(
    parameter int DUR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate,
    input  logic [DUR_W-1:0]  dur,
    output logic              expire
);

    logic [STEP_W-1:0] step_cnt;
    logic [DUR_W-1:0]  dur_cnt;

    assign expire = tick && (dur_cnt >= dur);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_cnt <= '0;
            dur_cnt  <= '0;
        end else if (reload) begin
            step_cnt <= '0;
            dur_cnt  <= '0;
        end else if (tick && !expire) begin
            if (step_cnt >= step_last(rate)) begin
                step_cnt <= '0;
                dur_cnt  <= dur_cnt + 1'b1;
            end else begin
                step_cnt <= step_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/inact_irq_flags.sv
module inact_irq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer,
    input  logic irq_clr,
    input  logic flush,
    input  logic gate,
    output logic irq_flag,
    output logic fifo_accept
);

    logic frozen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
            frozen   <= 1'b0;
        end else begin
            if (xfer)
                irq_flag <= 1'b1;
            else if (irq_clr)
                irq_flag <= 1'b0;

            if (xfer && gate)
                frozen <= 1'b1;
            else if (flush || irq_clr || !gate)
                frozen <= 1'b0;
        end
    end

    assign fifo_accept = !frozen;

endmodule

// File: rtl/inact_sleep_ctrl.sv
module inact_sleep_ctrl
    import inact_pkg::*;
#(
    parameter int               DUR_W     = 8,
    parameter int               SRC_N     = 6,
    parameter logic [SRC_N-1:0] RST_MASK  = 6'b011111,
    parameter logic [SRC_N-1:0] WAKE_MASK = 6'b001111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic [RATE_W-1:0] wake_rate,
    input  logic [RATE_W-1:0] sleep_rate,
    input  logic              slp_en,
    input  logic [DUR_W-1:0]  dur,
    input  logic              fifo_gate,
    input  logic              fifo_flush,
    input  logic              irq_clr,
    input  logic [SRC_N-1:0]  evt_src,
    output logic              in_sleep,
    output logic [RATE_W-1:0] rate_sel,
    output logic              irq_flag,
    output logic              fifo_accept
);

    inact_st_e st_q, st_d;
    logic      ev_restart, ev_wake;
    logic      tmr_reload, tmr_expire;
    logic      xfer;

    inact_evt_class #(
        .SRC_N    (SRC_N),
        .RST_MASK (RST_MASK),
        .WAKE_MASK(WAKE_MASK)
    ) i_class (
        .src    (evt_src),
        .restart(ev_restart),
        .wake   (ev_wake)
    );

    assign tmr_reload = (st_q != ST_WAKE) || ev_restart || !slp_en;

    inact_step_timer #(
        .DUR_W(DUR_W)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .reload(tmr_reload),
        .tick  (smp_stb),
        .rate  (wake_rate),
        .dur   (dur),
        .expire(tmr_expire)
    );

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_WAKE:  if (!tmr_reload && tmr_expire) st_d = ST_SLEEP;  // T_EXPIRE
            ST_SLEEP: if (ev_wake || !slp_en)        st_d = ST_WAKE;   // T_WAKE_EVT / T_DISABLE
        endcase
    end

    assign xfer = (st_d != st_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_WAKE;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        unique case (st_q)
            ST_WAKE: begin
                in_sleep = 1'b0;
                rate_sel = wake_rate;
            end
            ST_SLEEP: begin
                in_sleep = 1'b1;
                rate_sel = sleep_rate;
            end
        endcase
    end

    inact_irq_flags i_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer       (xfer),
        .irq_clr    (irq_clr),
        .flush      (fifo_flush),
        .gate       (fifo_gate),
        .irq_flag   (irq_flag),
        .fifo_accept(fifo_accept)
    );

endmodule

// File: rtl/inact_sleep_ctrl_chk.sv
module inact_sleep_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       slp_en,
    input logic [5:0] evt_src,
    input logic       irq_clr,
    input logic       fifo_gate,
    input logic       in_sleep,
    input logic       irq_flag,
    input logic       fifo_accept
);

    a_r5_wake_evt: assert property (@(posedge clk) disable iff (!rst_n)
        in_sleep && (|evt_src[3:0]) |=> !in_sleep);

    a_r4_disable_wake: assert property (@(posedge clk) disable iff (!rst_n)
        !slp_en |=> !in_sleep);

    a_r6_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
        in_sleep && slp_en && !(|evt_src[3:0]) |=> in_sleep);

    a_r8_restart_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_sleep && (|evt_src[4:0]) |=> !in_sleep);

    a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(in_sleep) |-> irq_flag);

    a_r9_flag_clr: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> (!irq_flag || !$stable(in_sleep)));

    a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fifo_gate) && !$stable(in_sleep) |-> !fifo_accept);

    a_r10_open: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_gate |=> fifo_accept);

endmodule

bind inact_sleep_ctrl inact_sleep_ctrl_chk i_chk (.*);

// File: tb/test_inact_sleep_ctrl.sv
module test_inact_sleep_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_stb = 1'b0;
    logic [2:0] wake_rate = 3'd3;
    logic [2:0] sleep_rate = 3'd6;
    logic       slp_en = 1'b0;
    logic [7:0] dur = 8'd0;
    logic       fifo_gate = 1'b0;
    logic       fifo_flush = 1'b0;
    logic       irq_clr = 1'b0;
    logic [5:0] evt_src = 6'd0;
    logic       in_sleep;
    logic [2:0] rate_sel;
    logic       irq_flag;
    logic       fifo_accept;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    inact_sleep_ctrl i_inact_sleep_ctrl (.*);

    function automatic int spp(input logic [2:0] code);
        case (code)
            3'd0: return 256;
            3'd1: return 128;
            3'd2: return 64;
            3'd3: return 32;
            3'd4: return 16;
            3'd5: return 4;
            3'd6: return 2;
            default: return 1;
        endcase
    endfunction

    // reference model from the requirements
    bit m_sleep, m_irq, m_frz;
    int m_q;
    always @(posedge clk) begin
        bit tr;
        tr = 1'b0;
        if (!rst_n) begin
            m_sleep = 0; m_irq = 0; m_frz = 0; m_q = 0;
        end else begin
            if (!m_sleep) begin
                if (!slp_en || (|evt_src[4:0])) m_q = 0;
                else if (smp_stb) begin
                    if (m_q >= int'(dur) * spp(wake_rate)) begin
                        tr = 1; m_sleep = 1; m_q = 0;
                    end else m_q++;
                end
            end else if ((|evt_src[3:0]) || !slp_en) begin
                tr = 1; m_sleep = 0; m_q = 0;
            end
            if (tr) m_irq = 1; else if (irq_clr) m_irq = 0;
            if (tr && fifo_gate) m_frz = 1;
            else if (fifo_flush || irq_clr || !fifo_gate) m_frz = 0;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (rst_n) begin
            chk(in_sleep, m_sleep, "R3 state vs model");
            chk(rate_sel, m_sleep ? sleep_rate : wake_rate, "R2 rate select");
            chk(irq_flag, m_irq, "R9 irq flag vs model");
            chk(fifo_accept, !m_frz, "R10 fifo accept vs model");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(in_sleep, 0, "R1 reset wake");
        chk(rate_sel, 3, "R1 reset rate");
        chk(irq_flag, 0, "R1 reset flag");
        chk(fifo_accept, 1, "R1 reset accept");

        // R11: zero duration sleeps on first clean strobe
        wake_rate = 3'd7; slp_en = 1'b1; smp_stb = 1'b1;
        tick(); smp_stb = 1'b0;
        chk(in_sleep, 1, "R11 dur0 sleep");
        chk(rate_sel, 6, "R2 sleep rate");
        chk(irq_flag, 1, "R9 flag after sleep");
        // R6: FIFO event does not wake
        evt_src = 6'b010000; tick(); evt_src = '0;
        chk(in_sleep, 1, "R6 fifo no wake");
        // R7: data ready ignored
        evt_src = 6'b100000; tick(); evt_src = '0;
        chk(in_sleep, 1, "R7 drdy ignored");
        irq_clr = 1'b1; tick(); irq_clr = 1'b0;
        chk(irq_flag, 0, "R9 clear");
        // R5: pulse source wakes
        evt_src = 6'b000100; tick(); evt_src = '0;
        chk(in_sleep, 0, "R5 wake event");
        chk(irq_flag, 1, "R9 flag after wake");
        // R8: restart beats expiry
        smp_stb = 1'b1; evt_src = 6'b000001; tick(); evt_src = '0;
        chk(in_sleep, 0, "R8 restart wins");
        tick(); smp_stb = 1'b0;
        chk(in_sleep, 1, "R8 then sleeps");
        // R4: clearing enable returns to wake
        slp_en = 1'b0; tick();
        chk(in_sleep, 0, "R4 disable wake");
        // R3: dur 2, code 5 (S=4): 9th strobe sleeps
        irq_clr = 1'b1; dur = 8'd2; wake_rate = 3'd5; tick(); irq_clr = 1'b0;
        slp_en = 1'b1;
        for (int i = 1; i <= 9; i++) begin
            smp_stb = 1'b1; tick(); smp_stb = 1'b0; tick();
            if (i == 8) chk(in_sleep, 0, "R3 still awake at 8");
            if (i == 9) chk(in_sleep, 1, "R3 sleep at 9");
        end
        // R10: gated transition freezes intake
        fifo_gate = 1'b1; slp_en = 1'b0; tick();
        chk(fifo_accept, 0, "R10 frozen");
        chk(in_sleep, 0, "R10 state change proceeds");
        fifo_flush = 1'b1; tick(); fifo_flush = 1'b0;
        chk(fifo_accept, 1, "R10 flush releases");

        // constrained random segments
        for (int s = 0; s < 40; s++) begin
            slp_en = 1'b0;
            wake_rate = 3'($urandom_range(7));
            sleep_rate = 3'($urandom_range(7));
            dur = 8'($urandom_range(3));
            fifo_gate = 1'($urandom_range(1));
            tick();
            slp_en = 1'b1;
            for (int c = 0; c < 300; c++) begin
                smp_stb = 1'($urandom_range(1));
                for (int b = 0; b < 6; b++) evt_src[b] = ($urandom_range(79) == 0);
                irq_clr = ($urandom_range(19) == 0);
                fifo_flush = ($urandom_range(19) == 0);
                if ($urandom_range(99) == 0) fifo_gate = ~fifo_gate;
                tick();
            end
            smp_stb = 1'b0; evt_src = '0; irq_clr = 1'b0; fifo_flush = 1'b0;
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule